// File: doc/BRIEF.md
# Event-Driven State Machine Node with Single-Slot Input Buffers

This block is one reactive node for a network of state machines that run on a shared clock but talk to each other only through events. Each of its three inputs lands in a single-slot buffer made of a presence bit and, where the input carries one, a data word. While every slot is empty the node sits idle. As soon as any slot fills, the node walks once through a fixed sequence of four phases, one cycle each. Idle is followed by detect, where all slots are copied into a snapshot and emptied. Next comes execute, where exactly one transition is computed from that snapshot alone. Last comes emit, where the chosen outputs are shown as one-cycle strobes with their data. The node then returns to idle.

The transition function is a small accumulator. Input 0 loads the state with its data. Input 1 adds its data to the state. Input 2 is a pure query event. Output 0 reports the new state when a query was seen. Output 1 signals an unsigned carry from an add. A new event that lands in a slot that is already full overwrites the slot and raises a sticky overrun flag for that input.

Top module: `gfn_node`

## Requirements
- R1: When rst_n is low at a rising clock edge, the state takes INIT_STATE (default 0x3C), all slots empty, all overrun flags clear, the sequencer returns to idle, and out_vld and out_data read zero from the next cycle on.
- R2: The phases run idle, detect, execute, emit and back to idle, one cycle each. The node leaves idle only when at least one slot is full, and no strobe appears in the three cycles that follow the capture of an event.
- R3: An event sampled into empty slots of an idle node at rising edge E gives its strobes in the cycle after edge E+3, for that one cycle only. out_vld is zero outside emit, and each out_data slice is zero while its strobe is low.
- R4: The snapshot is taken in the detect cycle. An event that arrives at the detect edge or later has no effect on the transition in progress.
- R5: The detect edge empties every slot, except that an event arriving at that same edge is kept and starts the next cycle of phases.
- R6: A second event on a slot that is full and not being cleared replaces the stored data, and the slot stays full.
- R7: ovr[i] sets when input i overwrites a full slot that is not being cleared on that edge, and it stays set until reset.
- R8: Next state: when input 0 (load) is in the snapshot, its data. Otherwise, when input 1 (add) is in the snapshot, (state + data1) mod 2^DW. Otherwise, the state is unchanged. Load has priority over add.
- R9: Output 0 (out_vld[0], out_data[DW-1:0]) is emitted exactly when input 2 (query) is in the snapshot, and it carries the next state. The data field of input 2 has no effect.
- R10: Output 1 (out_vld[1], out_data[2*DW-1:DW]) is emitted exactly when add is present, load is absent and state + data1 >= 2^DW, and it carries data1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_ev | input | 3 | Event strobes, bit 0 load, bit 1 add, bit 2 query |
| in_data | input | 3*DW (24) | Event data, slice i for input i |
| out_vld | output | 2 | One-cycle output strobes |
| out_data | output | 2*DW (16) | Output data, slice k for output k, zero when not emitted |
| ovr | output | 3 | Sticky overrun flag per input |

## Verification
An event that the bench drives for one cycle, and that is sampled at edge E, must leave out_vld low after edges E, E+1 and E+2. The strobes and data are due only after edge E+3 and must be gone after edge E+4. The bench reads every output at the falling edge between these rising edges, so each of those five cycles is checked once. An event held back by the detect edge is due four cycles later, after edge E+7. An overrun flag is due one edge after the overwriting event. The sweep pairs a grid of loaded states and add operands with every pattern of present inputs. It predicts each strobe and data word with its own arithmetic model.

// File: rtl/gfn_pkg.sv
// Shared definitions for the event-driven node: input roles, counts and
// the phase encoding used by the sequencer and the top level.
package gfn_pkg;
    localparam int N_IN     = 3;
    localparam int N_OUT    = 2;
    localparam int IDX_LOAD = 0;
    localparam int IDX_ADD  = 1;
    localparam int IDX_QRY  = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DETECT = 2'd1,
        PH_EXEC   = 2'd2,
        PH_EMIT   = 2'd3
    } phase_t;
endpackage

// File: rtl/gfn_evbuf.sv
// Single-slot event buffer for one input.
// Does: holds a presence bit and, when HAS_DATA is set, the latest data word.
// Assumes: an incoming event wins over a clear on the same edge; an event
// onto a full slot that is not being cleared overwrites it and sets a
// sticky overrun flag.
module gfn_evbuf #(
    parameter int DW       = 8,
    parameter bit HAS_DATA = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    input  logic [DW-1:0] data_i,
    input  logic          clr_i,
    output logic          full_o,
    output logic [DW-1:0] data_o,
    output logic          ovr_o
);
    logic full_q;
    logic ovr_q;

    // Presence bit: set by an event, cleared by the consumer unless refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (ev_i) begin
            full_q <= 1'b1;
        end else if (clr_i) begin
            full_q <= 1'b0;
        end
    end

    // Overrun flag: sticky until reset once an event overwrites a held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (ev_i && full_q && !clr_i) begin
            ovr_q <= 1'b1;
        end
    end

    generate
        if (HAS_DATA) begin : g_data
            logic [DW-1:0] data_q;
            // Data word: the latest event's value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                end else if (ev_i) begin
                    data_q <= data_i;
                end
            end
            assign data_o = data_q;
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^data_i;
            assign data_o      = '0;
        end
    endgenerate

    assign full_o = full_q;
    assign ovr_o  = ovr_q;

    // R5: a clear with no new event empties the slot
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ev_i) |=> !full_o);
    // R5: an event on the clear edge is kept
    a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> full_o);
    // R6: a full slot stays full until cleared
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clr_i) |=> full_o);
    // R7: overrun flag is sticky
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> ovr_o);
    // R7: flag rises only on an overwrite
    a_r7_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_o && !(ev_i && full_o && !clr_i)) |=> !ovr_o);
endmodule

// File: rtl/gfn_seq.sv
// Phase sequencer: idle -> detect -> exec -> emit -> idle.
// Does: leaves idle only when some input slot is full; every other phase
// lasts exactly one cycle so phases never overlap.
// Assumes: any_i is the OR of the slot presence bits.
module gfn_seq
    import gfn_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   any_i,
    output phase_t phase_o
);
    phase_t ph_q;
    phase_t ph_d;

    // Next phase decision.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:   if (any_i) ph_d = PH_DETECT;
            PH_DETECT: ph_d = PH_EXEC;
            PH_EXEC:   ph_d = PH_EMIT;
            PH_EMIT:   ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase_o = ph_q;

    // R2: fixed order, one cycle each
    a_r2_detect_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_DETECT) |=> (phase_o == PH_EXEC));
    a_r2_exec_to_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EXEC) |=> (phase_o == PH_EMIT));
    a_r2_emit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EMIT) |=> (phase_o == PH_IDLE));
    // R2: idle waits for an event
    a_r2_idle_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_IDLE && !any_i) |=> (phase_o == PH_IDLE));
endmodule

// File: rtl/gfn_xfer.sv
// Transition and output logic with the state register.
// Does: in the exec cycle computes the next state (load beats add) and the
// two output events from the snapshot, registering strobes for the emit cycle.
// Assumes: step_i is high for exactly one cycle per phase cycle, and the
// snapshot inputs are stable while it is high.
module gfn_xfer
    import gfn_pkg::*;
#(
    parameter int              DW         = 8,
    parameter logic [DW-1:0]   INIT_STATE = 8'h3C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic [N_IN-1:0]     snap_p_i,
    input  logic [DW-1:0]       load_d_i,
    input  logic [DW-1:0]       add_d_i,
    output logic [N_OUT-1:0]    out_vld_o,
    output logic [N_OUT*DW-1:0] out_data_o
);
    logic [DW-1:0]       st_q;
    logic [DW:0]         sum_w;
    logic [DW-1:0]       nxt_w;
    logic [N_OUT-1:0]    emit_w;
    logic [N_OUT-1:0]    vld_q;
    logic [N_OUT*DW-1:0] pay_q;

    // Memoryless transition: next state and output selection.
    always_comb begin
        sum_w = {1'b0, st_q} + {1'b0, add_d_i};
        if (snap_p_i[IDX_LOAD]) begin
            nxt_w = load_d_i;
        end else if (snap_p_i[IDX_ADD]) begin
            nxt_w = sum_w[DW-1:0];
        end else begin
            nxt_w = st_q;
        end
        emit_w[0] = snap_p_i[IDX_QRY];
        emit_w[1] = snap_p_i[IDX_ADD] && !snap_p_i[IDX_LOAD] && sum_w[DW];
    end

    // State register: updated only in the exec cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= INIT_STATE;
        end else if (step_i) begin
            st_q <= nxt_w;
        end
    end

    // Output strobes and data: loaded in exec, shown for the emit cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            pay_q <= '0;
        end else if (step_i) begin
            vld_q           <= emit_w;
            pay_q[DW-1:0]   <= emit_w[0] ? nxt_w   : '0;
            pay_q[2*DW-1:DW] <= emit_w[1] ? add_d_i : '0;
        end else begin
            vld_q <= '0;
            pay_q <= '0;
        end
    end

    assign out_vld_o  = vld_q;
    assign out_data_o = pay_q;

    // R8: state changes only on a transition step
    a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (st_q == $past(st_q)));
    // R3: strobes last one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_vld_o) |=> !(|out_vld_o));
    // R3: no strobe unless the previous cycle was a step
    a_r3_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> !(|out_vld_o));

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_zero
            // R3: data slice is zero while its strobe is low
            a_r3_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !out_vld_o[k] |-> (out_data_o[k*DW +: DW] == '0));
        end
    endgenerate
endmodule

// File: rtl/gfn_node.sv
// Top of the event-driven node.
// Does: one single-slot buffer per input, a four-phase sequencer, a snapshot
// register loaded in detect (which also empties the slots), and the
// transition/output logic stepped in exec.
// Assumes: input 2 is a pure event; its data field is ignored.
module gfn_node
    import gfn_pkg::*;
#(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] INIT_STATE = 8'h3C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_IN-1:0]     in_ev,
    input  logic [N_IN*DW-1:0]  in_data,
    output logic [N_OUT-1:0]    out_vld,
    output logic [N_OUT*DW-1:0] out_data,
    output logic [N_IN-1:0]     ovr
);
    localparam logic [N_IN-1:0] HAS_DATA_MASK = N_IN'((1 << IDX_QRY) ^ ((1 << N_IN) - 1));

    phase_t          phase;
    logic [N_IN-1:0] full;
    logic [DW-1:0]   buf_data [N_IN];
    logic            clr;
    logic [N_IN-1:0] snap_p;
    logic [DW-1:0]   snap_load;
    logic [DW-1:0]   snap_add;
    logic            unused_qry_data;

    assign clr = (phase == PH_DETECT);

    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_buf
            gfn_evbuf #(
                .DW       (DW),
                .HAS_DATA (HAS_DATA_MASK[i])
            ) u_buf (
                .clk    (clk),
                .rst_n  (rst_n),
                .ev_i   (in_ev[i]),
                .data_i (in_data[i*DW +: DW]),
                .clr_i  (clr),
                .full_o (full[i]),
                .data_o (buf_data[i]),
                .ovr_o  (ovr[i])
            );
        end
    endgenerate

    assign unused_qry_data = ^buf_data[IDX_QRY];

    gfn_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_i   (|full),
        .phase_o (phase)
    );

    // Snapshot register: captures every slot in the detect cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_p    <= '0;
            snap_load <= '0;
            snap_add  <= '0;
        end else if (clr) begin
            snap_p    <= full;
            snap_load <= buf_data[IDX_LOAD];
            snap_add  <= buf_data[IDX_ADD];
        end
    end

    gfn_xfer #(
        .DW         (DW),
        .INIT_STATE (INIT_STATE)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (phase == PH_EXEC),
        .snap_p_i   (snap_p),
        .load_d_i   (snap_load),
        .add_d_i    (snap_add),
        .out_vld_o  (out_vld),
        .out_data_o (out_data)
    );

    // R3: strobes only in the emit phase
    a_r3_emit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_vld) |-> (phase == PH_EMIT));
    // R4: the snapshot does not move outside detect
    a_r4_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DETECT) |=> (snap_p == $past(snap_p)));
    // R2: a full slot in idle starts detect
    a_r2_idle_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && |full) |=> (phase == PH_DETECT));
endmodule

// File: tb/sim_gfn_node.sv
`timescale 1ns/1ps
module sim_gfn_node;
    localparam int           DW   = 8;
    localparam logic [7:0]   INIT = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  in_ev = '0;
    logic [23:0] in_data = '0;
    logic [1:0]  out_vld;
    logic [15:0] out_data;
    logic [2:0]  ovr;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_state;

    always #2.5 clk = ~clk;

    gfn_node #(.DW(DW), .INIT_STATE(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .in_ev(in_ev), .in_data(in_data),
        .out_vld(out_vld), .out_data(out_data), .ovr(ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        check(req, {30'd0, out_vld}, 32'd0);
        check(req, {16'd0, out_data}, 32'd0);
    endtask

    // One event pattern from an idle, empty node; checks all five cycles.
    task automatic txn(input logic [2:0] pres, input logic [7:0] d0,
                       input logic [7:0] d1, input logic [7:0] d2);
        logic [8:0] sum;
        logic [7:0] nxt;
        logic [1:0] ev;
        logic [15:0] dat;
        sum = {1'b0, m_state} + {1'b0, d1};
        if (pres[0])      nxt = d0;
        else if (pres[1]) nxt = sum[7:0];
        else              nxt = m_state;
        ev[0] = pres[2];
        ev[1] = pres[1] && !pres[0] && sum[8];
        dat[7:0]  = ev[0] ? nxt : 8'h00;
        dat[15:8] = ev[1] ? d1  : 8'h00;
        @(negedge clk);
        in_ev = pres; in_data = {d2, d1, d0};
        @(negedge clk);
        in_ev = '0;
        quiet("R2 after capture edge");
        @(negedge clk);
        quiet("R2 detect cycle");
        @(negedge clk);
        quiet("R2 exec cycle");
        @(negedge clk);
        check("R3 strobes", {30'd0, out_vld}, {30'd0, ev});
        check("R8 R9 state via output 0", {24'd0, out_data[7:0]}, {24'd0, dat[7:0]});
        check("R10 carry output", {24'd0, out_data[15:8]}, {24'd0, dat[15:8]});
        @(negedge clk);
        quiet("R3 one-cycle strobe");
        m_state = nxt;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        m_state = INIT;
        repeat (3) @(negedge clk);
        quiet("R1 reset outputs");
        check("R1 reset overrun", {29'd0, ovr}, 32'd0);
        rst_n = 1'b1;

        // R1 / R9: initial state reported by a query
        txn(3'b100, 8'h00, 8'h00, 8'hA5);

        // R8 R9 R10: sweep states, operands and every presence pattern
        for (int s = 0; s < 256; s += 51) begin
            for (int d = 0; d < 256; d += 37) begin
                for (int p = 0; p < 8; p++) begin
                    txn(3'b001, 8'(s), 8'h00, 8'h00);
                    txn(3'(p), 8'(d ^ 8'h5A), 8'(d), 8'(d + s));
                end
            end
        end

        // R4 R5: query arriving on the detect edge is kept for the next cycle
        txn(3'b001, 8'h10, 8'h00, 8'h00);
        @(negedge clk);
        in_ev = 3'b001; in_data = {8'h00, 8'h00, 8'hC7};
        @(negedge clk);
        in_ev = '0;
        @(negedge clk);
        in_ev = 3'b100;
        @(negedge clk);
        in_ev = '0;
        quiet("R4 detect edge");
        @(negedge clk);
        quiet("R4 late query excluded from first transition");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            quiet("R5 gap before second cycle");
        end
        @(negedge clk);
        check("R5 kept query strobe", {30'd0, out_vld}, 32'd1);
        check("R4 state from first snapshot", {24'd0, out_data[7:0]}, 32'hC7);
        check("R7 no overrun on clear edge", {29'd0, ovr}, 32'd0);
        m_state = 8'hC7;
        @(negedge clk);
        quiet("R5 single strobe");

        // R6 R7: overwrite of a full load slot
        @(negedge clk);
        in_ev = 3'b101; in_data = {8'h00, 8'h00, 8'h21};
        @(negedge clk);
        check("R7 flag before overwrite", {29'd0, ovr}, 32'd0);
        in_ev = 3'b001; in_data = {8'h00, 8'h00, 8'h9E};
        @(negedge clk);
        in_ev = '0;
        check("R7 flag after overwrite", {29'd0, ovr}, 32'd1);
        @(negedge clk);
        quiet("R6 detect cycle");
        @(negedge clk);
        check("R6 strobe", {30'd0, out_vld}, 32'd1);
        check("R6 newer data wins", {24'd0, out_data[7:0]}, 32'h9E);
        m_state = 8'h9E;
        repeat (3) @(negedge clk);
        check("R7 flag sticky", {29'd0, ovr}, 32'd1);

        // R1: reset in the middle of a phase cycle
        @(negedge clk);
        in_ev = 3'b001; in_data = {8'h00, 8'h00, 8'h77};
        @(negedge clk);
        in_ev = '0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        quiet("R1 outputs in reset");
        check("R1 overrun cleared", {29'd0, ovr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        m_state = INIT;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            quiet("R1 buffers emptied by reset");
        end
        txn(3'b100, 8'h00, 8'h00, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule